// File: doc/BRIEF.md
# SPI Master Frame Engine

This block is the master side of a serial peripheral link. A single start pulse loads a parallel word together with its transfer settings. The engine then asserts one of four slave-select lines and waits a programmed setup time. It clocks the frame out on MOSI while sampling MISO, waits a programmed release time, and drops the select line. It then returns the received word with a one-cycle done pulse. After a programmed inter-frame gap it accepts the next start.

The SCK rate comes from a two-field prescaler. Frame length is picked by a 4-bit code that covers 4 to 32 bits. Shift order, clock polarity and clock phase are selectable. An optional even or odd parity bit is appended to each frame and checked on receive. Two internal loopback paths return MOSI to the receiver, either unchanged or inverted, so the receive and parity logic can be tested without an external slave.

Top module: `spi_xfer_engine`

## Requirements
- R1: While no frame runs, `sck` rests at the level of `cpol` (0 = low, 1 = high).
- R2: MOSI changes only on launch edges and is stable across sampling edges. With `cpha`=0, the sampling edges are the odd SCK edges of the frame (1st, 3rd, ...). With `cpha`=1, they are the even edges. A sampling edge leaves `sck` high when `cpol`==`cpha`, and low otherwise.
- R3: Every SCK half period lasts H = (`div_sel`+1)·2^`mult_sel` system clocks. `mult_sel` is treated as 0 whenever `div_sel` < 8.
- R4: `len_code` values 0..12 select 4..16 data bits, 13 selects 20, 14 selects 24 and 15 selects 32. A frame has exactly 2·(data bits + parity bit) SCK edges.
- R5: With `lsb_first`=0, bit n-1 of `tx_word` goes first. With `lsb_first`=1, bit 0 goes first. Received bits are placed back into the same positions.
- R6: `par_mode` 2'b01 appends an even parity bit after the data, 2'b11 appends an odd parity bit, and 2'b00 or 2'b10 appends none.
- R7: `par_err` pulses for one cycle, together with `done`, when parity is enabled and the received parity bit does not satisfy the same rule over the received data bits.
- R8: The first SCK edge comes exactly 2·(`setup_dly`+1)·H system clocks after the select line goes active.
- R9: The select line goes inactive exactly 2·(`hold_dly`+1)·H system clocks after the last SCK edge. `done` pulses in that same cycle, with `rx_word` holding the received data and zeros above the frame length.
- R10: `busy` falls exactly 2·(`gap_dly`+1)·H + 2 system clocks after `done`.
- R11: `loop_mode` 2'b01 receives MOSI, 2'b10 receives inverted MOSI, and 2'b00 or 2'b11 receives the `miso` pin.
- R12: Only line `ss_sel` of `ss_out` goes active during a frame. Line i is active at the level `ss_pol[i]` (1 = active high). All other lines stay at their inactive level.
- R13: A start pulse while `busy` is high is ignored. The running frame keeps its data and edge count, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (accepted when idle) |
| tx_word | input | 32 | Word to send |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | Sampling on even edges when 1 |
| lsb_first | input | 1 | Shift order select |
| par_mode | input | 2 | Parity: 01 even, 11 odd, else off |
| len_code | input | 4 | Frame length code |
| div_sel | input | 4 | Prescaler divider field |
| mult_sel | input | 2 | Prescaler power-of-two field |
| setup_dly | input | 3 | Setup time minus one, in SCK periods |
| hold_dly | input | 3 | Release time minus one, in SCK periods |
| gap_dly | input | 3 | Gap time minus one, in SCK periods |
| loop_mode | input | 2 | Receive source select |
| ss_sel | input | 2 | Select line index |
| ss_pol | input | 4 | Active level per select line |
| miso | input | 1 | Serial data from slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| ss_out | output | 4 | Slave-select lines |
| busy | output | 1 | Frame or gap in progress |
| done | output | 1 | One-cycle frame completion pulse |
| par_err | output | 1 | Parity mismatch pulse |
| rx_word | output | 32 | Received word |

## Verification
After the start edge, every output is a register or is decoded straight from one. The select line therefore shows in the first sample after that edge. SCK edges follow at multiples of H, and `done` and the select release land in the same cycle. `busy` falls 2·(gap+1)·H+2 clocks after `done`. The bench samples every output 1 ns after each rising clock edge and stamps every SCK transition, select change, `done` and `busy` fall with a cycle count. It then compares the differences against these formulas computed from the programmed fields. MOSI is judged from the sample taken before each sampling edge, so that a late launch or an early change is detected.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_RELEASE,
    ST_GAP,
    ST_TAIL
  } xfer_state_t;

  localparam logic [1:0] LB_DIRECT = 2'b01;
  localparam logic [1:0] LB_INVERT = 2'b10;

  // Data bits per frame for a 4-bit length code: linear up to 16, then 20/24/32.
  function automatic int unsigned frame_len(input logic [3:0] code);
    case (code)
      4'd13:   return 20;
      4'd14:   return 24;
      4'd15:   return 32;
      default: return 32'(code) + 32'd4;
    endcase
  endfunction

endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int DIV_W  = 4,
  parameter int MULT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DIV_W-1:0]  div,
  input  logic [MULT_W-1:0] mult,
  output logic              tick
);
  localparam int CNT_W = DIV_W + (1 << MULT_W) - 1;

  logic [CNT_W-1:0]  cnt;
  logic [MULT_W-1:0] mult_eff;
  logic [CNT_W:0]    half;

  // The multiplier only applies to the upper half of the divider range.
  assign mult_eff = div[DIV_W-1] ? mult : '0;
  assign half     = ({{(CNT_W + 1 - DIV_W){1'b0}}, div} + (CNT_W + 1)'(1)) << mult_eff;
  assign tick     = en && ({1'b0, cnt} == half - (CNT_W + 1)'(1));

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + CNT_W'(1);
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> ({1'b0, cnt} < half));

endmodule

// File: rtl/spi_io_stage.sv
module spi_io_stage #(
  parameter int NUM_SS = 4,
  parameter int SEL_W  = 2
) (
  input  logic              ss_act,
  input  logic [SEL_W-1:0]  sel,
  input  logic [NUM_SS-1:0] pol,
  input  logic [1:0]        loop_mode,
  input  logic              mosi,
  input  logic              miso_pin,
  output logic [NUM_SS-1:0] ss_lines,
  output logic              miso_eff
);
  import spi_xfer_pkg::*;

  for (genvar g = 0; g < NUM_SS; g++) begin : g_line
    assign ss_lines[g] = (ss_act && (sel == SEL_W'(g))) ? pol[g] : ~pol[g];
  end

  always_comb begin
    case (loop_mode)
      LB_DIRECT: miso_eff = mosi;
      LB_INVERT: miso_eff = ~mosi;
      default:   miso_eff = miso_pin;
    endcase
  end

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_SS = 4,
  parameter int DIV_W  = 4,
  parameter int MULT_W = 2,
  parameter int DLY_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [DATA_W-1:0]         tx_word,
  input  logic                      cpol,
  input  logic                      cpha,
  input  logic                      lsb_first,
  input  logic [1:0]                par_mode,
  input  logic [3:0]                len_code,
  input  logic [DIV_W-1:0]          div_sel,
  input  logic [MULT_W-1:0]         mult_sel,
  input  logic [DLY_W-1:0]          setup_dly,
  input  logic [DLY_W-1:0]          hold_dly,
  input  logic [DLY_W-1:0]          gap_dly,
  input  logic [1:0]                loop_mode,
  input  logic [$clog2(NUM_SS)-1:0] ss_sel,
  input  logic [NUM_SS-1:0]         ss_pol,
  input  logic                      miso,
  output logic                      sck,
  output logic                      mosi,
  output logic [NUM_SS-1:0]         ss_out,
  output logic                      busy,
  output logic                      done,
  output logic                      par_err,
  output logic [DATA_W-1:0]         rx_word
);
  localparam int SEL_W  = $clog2(NUM_SS);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int NB_W   = $clog2(DATA_W + 2);
  localparam int EDGE_W = NB_W + 1;

  xfer_state_t        state;
  logic               cpol_q, cpha_q, lsb_q, par_en_q, par_odd_q, tx_par_q;
  logic [DIV_W-1:0]   div_q;
  logic [MULT_W-1:0]  mult_q;
  logic [NB_W-1:0]    nd_q;
  logic [DLY_W-1:0]   setup_q, hold_q, gap_q;
  logic [SEL_W-1:0]   sel_q;
  logic [1:0]         loop_q;
  logic [DATA_W-1:0]  tx_q, rx_d;
  logic               rx_p, ss_act, tail, tick, miso_eff;
  logic [DLY_W:0]     hcnt;
  logic [EDGE_W-1:0]  ecnt;

  // Start-time decode of the incoming word.
  logic [NB_W-1:0]    nd_in, first_idx;
  logic [DATA_W-1:0]  mask_in;
  logic               par_in, first_bit_in;

  assign nd_in     = NB_W'(frame_len(len_code));
  assign first_idx = nd_in - 1'b1;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) mask_in[i] = (i < int'(nd_in));
  end

  assign par_in       = par_mode[1] ^ (^(tx_word & mask_in));
  assign first_bit_in = lsb_first ? tx_word[0] : tx_word[first_idx[IDX_W-1:0]];

  // Edge bookkeeping for the running frame.
  logic [NB_W-1:0]   nb, edge_j, launch_j, launch_idx, samp_idx;
  logic              edge_odd, edge_fire, do_launch, do_sample, last_edge, launch_bit;
  logic              setup_end, hold_end, gap_end;

  assign nb         = nd_q + NB_W'(par_en_q);
  assign edge_j     = ecnt[EDGE_W-1:1];
  assign edge_odd   = ~ecnt[0];
  assign launch_j   = cpha_q ? edge_j : edge_j + 1'b1;
  assign launch_idx = lsb_q ? launch_j : nd_q - 1'b1 - launch_j;
  assign samp_idx   = lsb_q ? edge_j : nd_q - 1'b1 - edge_j;
  assign launch_bit = (launch_j < nd_q) ? tx_q[launch_idx[IDX_W-1:0]] : tx_par_q;

  assign setup_end  = (hcnt == {setup_q, 1'b1});
  assign hold_end   = (hcnt == {hold_q, 1'b1});
  assign gap_end    = (hcnt == {gap_q, 1'b1});

  assign edge_fire  = tick && (((state == ST_SETUP) && setup_end) || (state == ST_XFER));
  assign do_launch  = edge_fire && (edge_odd == cpha_q) && (launch_j < nb);
  assign do_sample  = edge_fire && (edge_odd != cpha_q);
  assign last_edge  = ((ecnt + EDGE_W'(1)) == {nb, 1'b0});

  assign busy = (state != ST_IDLE);

  spi_baud_gen #(
    .DIV_W  (DIV_W),
    .MULT_W (MULT_W)
  ) u_baud (
    .clk  (clk),
    .rst  (rst),
    .en   ((state != ST_IDLE) && (state != ST_TAIL)),
    .div  (div_q),
    .mult (mult_q),
    .tick (tick)
  );

  spi_io_stage #(
    .NUM_SS (NUM_SS),
    .SEL_W  (SEL_W)
  ) u_io (
    .ss_act    (ss_act),
    .sel       (sel_q),
    .pol       (ss_pol),
    .loop_mode (loop_q),
    .mosi      (mosi),
    .miso_pin  (miso),
    .ss_lines  (ss_out),
    .miso_eff  (miso_eff)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sck       <= 1'b0;
      mosi      <= 1'b0;
      ss_act    <= 1'b0;
      done      <= 1'b0;
      par_err   <= 1'b0;
      rx_word   <= '0;
      rx_d      <= '0;
      rx_p      <= 1'b0;
      hcnt      <= '0;
      ecnt      <= '0;
      tail      <= 1'b0;
      cpol_q    <= 1'b0;
      cpha_q    <= 1'b0;
      lsb_q     <= 1'b0;
      par_en_q  <= 1'b0;
      par_odd_q <= 1'b0;
      tx_par_q  <= 1'b0;
      div_q     <= '0;
      mult_q    <= '0;
      nd_q      <= '0;
      setup_q   <= '0;
      hold_q    <= '0;
      gap_q     <= '0;
      sel_q     <= '0;
      loop_q    <= '0;
      tx_q      <= '0;
    end else begin
      done    <= 1'b0;
      par_err <= 1'b0;

      if (do_launch) mosi <= launch_bit;
      if (do_sample) begin
        if (edge_j < nd_q) rx_d[samp_idx[IDX_W-1:0]] <= miso_eff;
        else               rx_p <= miso_eff;
      end
      if (edge_fire) begin
        sck  <= ~sck;
        ecnt <= ecnt + EDGE_W'(1);
      end

      case (state)
        ST_IDLE: begin
          sck <= cpol;
          if (start) begin
            state     <= ST_SETUP;
            ss_act    <= 1'b1;
            hcnt      <= '0;
            ecnt      <= '0;
            rx_d      <= '0;
            rx_p      <= 1'b0;
            mosi      <= first_bit_in;
            cpol_q    <= cpol;
            cpha_q    <= cpha;
            lsb_q     <= lsb_first;
            par_en_q  <= par_mode[0];
            par_odd_q <= par_mode[1];
            tx_par_q  <= par_in;
            div_q     <= div_sel;
            mult_q    <= mult_sel;
            nd_q      <= nd_in;
            setup_q   <= setup_dly;
            hold_q    <= hold_dly;
            gap_q     <= gap_dly;
            sel_q     <= ss_sel;
            loop_q    <= loop_mode;
            tx_q      <= tx_word;
          end
        end
        ST_SETUP: if (tick) begin
          if (setup_end) state <= ST_XFER;
          else           hcnt  <= hcnt + 1'b1;
        end
        ST_XFER: if (tick && last_edge) begin
          state <= ST_RELEASE;
          hcnt  <= '0;
        end
        ST_RELEASE: if (tick) begin
          if (hold_end) begin
            ss_act  <= 1'b0;
            done    <= 1'b1;
            rx_word <= rx_d;
            par_err <= par_en_q && (rx_p != (par_odd_q ^ (^rx_d)));
            state   <= ST_GAP;
            hcnt    <= '0;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        ST_GAP: if (tick) begin
          if (gap_end) begin
            state <= ST_TAIL;
            tail  <= 1'b0;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (tail) state <= ST_IDLE;
          else      tail  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R12
  ss_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~(ss_out ^ ss_pol)));

  // R1
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(state) == ST_IDLE)) |-> (sck == $past(cpol)));

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (ss_out == ~ss_pol));

  // R7
  perr_done_chk: assert property (@(posedge clk) disable iff (rst)
    par_err |-> done);

  // R4
  edge_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_XFER) |-> (ecnt < {nb, 1'b0}));

endmodule

// File: tb/tb_spi_xfer_engine.sv
`timescale 1ns/1ps
module tb_spi_xfer_engine;
  logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [31:0] tx_word = '0;
  logic        cpol = 0, cpha = 0, lsb_first = 0, miso = 0;
  logic [1:0]  par_mode = 0, loop_mode = 0, ss_sel = 0;
  logic [3:0]  len_code = 0, div_sel = 0, ss_pol = 0;
  logic [1:0]  mult_sel = 0;
  logic [2:0]  setup_dly = 0, hold_dly = 0, gap_dly = 0;
  logic        sck, mosi, busy, done, par_err;
  logic [3:0]  ss_out;
  logic [31:0] rx_word;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  spi_xfer_engine dut (
    .clk(clk), .rst(rst), .start(start), .tx_word(tx_word), .cpol(cpol), .cpha(cpha),
    .lsb_first(lsb_first), .par_mode(par_mode), .len_code(len_code), .div_sel(div_sel),
    .mult_sel(mult_sel), .setup_dly(setup_dly), .hold_dly(hold_dly), .gap_dly(gap_dly),
    .loop_mode(loop_mode), .ss_sel(ss_sel), .ss_pol(ss_pol), .miso(miso), .sck(sck),
    .mosi(mosi), .ss_out(ss_out), .busy(busy), .done(done), .par_err(par_err), .rx_word(rx_word)
  );

  function automatic int nbits(input logic [3:0] c);
    if (c <= 12) return int'(c) + 4;
    if (c == 13) return 20;
    if (c == 14) return 24;
    return 32;
  endfunction

  function automatic int half_clks(input logic [3:0] d, input logic [1:0] m);
    return (int'(d) + 1) * ((d >= 8) ? (1 << m) : 1);
  endfunction

  function automatic logic [31:0] maskn(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic par_of(input logic [31:0] d, input int n, input logic odd);
    return odd ^ (^(d & maskn(n)));
  endfunction

  function automatic logic exp_bit(input logic [31:0] d, input int n, input logic lsb,
                                   input logic p, input int j);
    if (j < n) return lsb ? d[j] : d[n-1-j];
    return p;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic pl, input logic ph, input logic lsb, input logic [1:0] pm,
                         input logic [3:0] lc, input logic [3:0] dv, input logic [1:0] ml,
                         input logic [2:0] su, input logic [2:0] rl, input logic [2:0] gp,
                         input logic [1:0] lb, input logic [1:0] sl, input logic [3:0] pol,
                         input logic mi, input logic [31:0] w);
    @(negedge clk);
    cpol = pl; cpha = ph; lsb_first = lsb; par_mode = pm; len_code = lc; div_sel = dv;
    mult_sel = ml; setup_dly = su; hold_dly = rl; gap_dly = gp; loop_mode = lb;
    ss_sel = sl; ss_pol = pol; miso = mi; tx_word = w;
  endtask

  task automatic run_frame(input bit extra);
    int n, nb, h, t, edges, ss_on, ss_off, first_e, last_e, done_t, busy_low;
    int spacing_bad, bits_bad, dir_bad, ss_bad, perr_cnt, done_cnt;
    logic pen, podd, tpar, exp_rp, exp_err, prev_sck, prev_mosi, perr_got;
    logic [31:0] w, exp_rd, rx_got;
    logic [3:0] act;
    n = nbits(len_code); pen = par_mode[0]; podd = par_mode[1];
    nb = n + int'(pen); h = half_clks(div_sel, mult_sel); w = tx_word;
    tpar = par_of(w, n, podd);
    case (loop_mode)
      2'b01:   begin exp_rd = w & maskn(n);  exp_rp = tpar;  end
      2'b10:   begin exp_rd = ~w & maskn(n); exp_rp = ~tpar; end
      default: begin exp_rd = miso ? maskn(n) : 32'd0; exp_rp = miso; end
    endcase
    exp_err = pen && (exp_rp != par_of(exp_rd, n, podd));
    @(posedge clk); #1;
    // R1: idle clock level after one idle cycle with this polarity
    chk(sck == cpol, "R1 idle sck", sck, cpol);
    @(negedge clk); start = 1'b1;
    prev_sck = sck; prev_mosi = mosi; t = 0; edges = 0; ss_on = -1; ss_off = -1;
    first_e = -1; last_e = -1; done_t = -1; busy_low = -1; spacing_bad = 0; bits_bad = 0;
    dir_bad = 0; ss_bad = 0; perr_cnt = 0; done_cnt = 0; rx_got = '0; perr_got = 0;
    while (busy_low < 0 && t < 40000) begin
      @(posedge clk); #1; t++;
      act = ~(ss_out ^ ss_pol);
      if ((act & ~(4'd1 << ss_sel)) != 4'd0) ss_bad++;
      if (act[ss_sel] && ss_on < 0) ss_on = t;
      if (!act[ss_sel] && ss_on >= 0 && ss_off < 0) ss_off = t;
      if (sck != prev_sck) begin
        edges++;
        if (edges == 1) first_e = t;
        else if (t - last_e != h) spacing_bad++;
        last_e = t;
        if ((cpha && edges % 2 == 0) || (!cpha && edges % 2 == 1)) begin
          if (sck != (cpol == cpha)) dir_bad++;
          if (prev_mosi != exp_bit(w, n, lsb_first, tpar, (edges - 1) / 2)) bits_bad++;
        end
      end
      if (done) begin done_cnt++; done_t = t; rx_got = rx_word; perr_got = par_err; end
      if (par_err) perr_cnt++;
      if (!busy) busy_low = t;
      prev_sck = sck; prev_mosi = mosi;
      if (t == 1) start = 1'b0;
      if (extra && t == 3) begin start = 1'b1; tx_word = ~w; end
      if (extra && t == 4) start = 1'b0;
    end
    tx_word = w;
    chk(ss_on == 1, "R12 select asserted after start", ss_on, 1);
    chk(ss_bad == 0, "R12 unselected lines stayed inactive", ss_bad, 0);
    chk(edges == 2 * nb, "R4 R13 SCK edge count", edges, 2 * nb);
    chk(spacing_bad == 0, "R3 SCK half period", spacing_bad, 0);
    chk(dir_bad == 0, "R2 sampling edge direction", dir_bad, 0);
    chk(bits_bad == 0, "R2 R5 R6 MOSI bit sequence", bits_bad, 0);
    chk(first_e - ss_on == 2 * (int'(setup_dly) + 1) * h, "R8 setup time",
        first_e - ss_on, 2 * (int'(setup_dly) + 1) * h);
    chk(ss_off - last_e == 2 * (int'(hold_dly) + 1) * h, "R9 release time",
        ss_off - last_e, 2 * (int'(hold_dly) + 1) * h);
    chk(done_cnt == 1 && done_t == ss_off, "R9 done with select release", done_t, ss_off);
    chk(rx_got == exp_rd, "R5 R9 R11 R13 received word", rx_got, exp_rd);
    chk(perr_got == exp_err && perr_cnt == int'(exp_err), "R7 parity error pulse",
        perr_cnt, exp_err);
    chk(busy_low - done_t == 2 * (int'(gap_dly) + 1) * h + 2, "R10 gap length",
        busy_low - done_t, 2 * (int'(gap_dly) + 1) * h + 2);
    if (extra) begin
      repeat (4) begin
        @(posedge clk); #1;
        chk(!busy && sck == cpol, "R13 no queued frame", busy, 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R13 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk(!busy && !done && !par_err, "R9 reset outputs quiet", {busy, done, par_err}, 0);
    chk(ss_out == ~ss_pol, "R12 reset selects inactive", ss_out, ~ss_pol);
    // directed corners: pl ph lsb par len div mult su rl gp loop sel pol miso word
    set_cfg(0, 0, 0, 2'b00, 4'd4,  4'd0,  2'd0, 3'd0, 3'd0, 3'd0, 2'b01, 2'd0, 4'b0000, 0, 32'hA5);
    run_frame(0);
    set_cfg(0, 1, 1, 2'b01, 4'd12, 4'd1,  2'd0, 3'd1, 3'd2, 3'd0, 2'b01, 2'd1, 4'b0010, 0, 32'h1234);
    run_frame(0);
    set_cfg(1, 0, 0, 2'b11, 4'd15, 4'd2,  2'd0, 3'd0, 3'd1, 3'd1, 2'b10, 2'd2, 4'b1111, 0, 32'hDEADBEEF);
    run_frame(0);
    set_cfg(1, 1, 0, 2'b01, 4'd13, 4'd0,  2'd0, 3'd0, 3'd0, 3'd2, 2'b00, 2'd3, 4'b1000, 1, 32'h5A5A5);
    run_frame(0);
    set_cfg(0, 0, 1, 2'b11, 4'd14, 4'd0,  2'd0, 3'd3, 3'd0, 3'd0, 2'b11, 2'd0, 4'b0101, 0, 32'hC3C3C3);
    run_frame(0);
    set_cfg(1, 1, 1, 2'b10, 4'd0,  4'd5,  2'd2, 3'd7, 3'd3, 3'd5, 2'b01, 2'd1, 4'b0000, 0, 32'h9);
    run_frame(0);
    set_cfg(0, 1, 0, 2'b00, 4'd0,  4'd15, 2'd3, 3'd0, 3'd0, 3'd0, 2'b01, 2'd2, 4'b0100, 0, 32'h6);
    run_frame(0);
    set_cfg(1, 0, 1, 2'b01, 4'd1,  4'd9,  2'd1, 3'd2, 3'd0, 3'd0, 2'b10, 2'd3, 4'b0000, 0, 32'h13);
    run_frame(0);
    set_cfg(0, 0, 0, 2'b01, 4'd4,  4'd0,  2'd0, 3'd0, 3'd0, 3'd0, 2'b10, 2'd0, 4'b0001, 0, 32'h3C);
    run_frame(0);
    set_cfg(0, 1, 0, 2'b11, 4'd6,  4'd1,  2'd0, 3'd1, 3'd1, 3'd1, 2'b01, 2'd2, 4'b0000, 0, 32'h2AB);
    run_frame(1);
    for (int k = 0; k < 30; k++) begin
      set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 4'($urandom),
              4'($urandom % 4), 2'($urandom), 3'($urandom), 3'($urandom), 3'($urandom),
              2'($urandom), 2'($urandom), 4'($urandom), 1'($urandom), $urandom);
      run_frame(k % 7 == 3);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule